// File: doc/BRIEF.md
# Compare-Based PWM Timer Bank

A bank of identical timer channels sharing one simple register bus. Each channel holds a 16-bit up-counter, a duty compare value, a period compare value and a small control field. While a channel's counter runs, it climbs from 0 to the period value and then returns to 0. The channel's pin sits at a programmable starting level until the counter reaches the duty value. It takes the opposite level from there through the period value. Each time the counter sits on the period value, a one-cycle full-compare pulse is emitted.

Counters are started and stopped through two shared write-one registers, one that sets and one that clears, so one write can touch many channels without a read-modify-write. A read-only status word shows which counters run. Software may also load a counter directly. When the pin enable is cleared, the pin either drops to its starting level at once or finishes the current period first, as a per-channel bit selects. The number of channels is a parameter (5, 6 or 8). Duty and period writes act at once, with no shadow copy.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every counter is stopped, every control, counter, duty and period register and the status word read 0, and every `pwm_o` and `full_o` bit is 0.
- R2: While its run bit is set, a channel's counter rises by one per clock, and in a cycle where it equals the period value it goes to 0 on the next edge. `full_o[n]` is 1 exactly in the cycles where channel n runs and its counter equals its period value.
- R3: With the pin enabled, `pwm_o[n]` shows the starting level while the counter is below the duty value, and the opposite level while the counter is at or above the duty value.
- R4: Control bit 1 sets the starting level (1 = high, 0 = low).
- R5: Control bit 0 enables the pin; once the enable has been cleared and the shutdown has taken effect, the pin holds the starting level whatever the counter does.
- R6: A write to the set word (shared address 1) starts channel n for each 1 in bit n, and a write to the clear word (shared address 2) stops it; 0 bits change nothing. The status word (shared address 0) reads the run bits in bits NUM_CH-1:0. A stopped counter keeps its value.
- R7: A write to a counter register loads that value on the next edge, and this load takes priority over counting and wrapping in the same cycle.
- R8: When the duty value exceeds the period value, the pin stays at the starting level.
- R9: Control bit 2 selects abrupt shutdown. With it set, a control write that clears the enable bit puts the pin at the starting level from the next cycle. With it clear, the pin keeps running until the cycle in which the counter equals the period value, and it reaches the starting level from the cycle after that.
- R10: Duty and period writes affect the output from the cycle after the write, with no wait for a period boundary.

Address map: the top address bit selects the shared words. With it 0, the address holds the channel index in bits ADDR_W-2:2 and the register in bits 1:0 (0 control, 1 counter, 2 duty, 3 period).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CW | Read data, combinational from rd_addr |
| pwm_o | output | NUM_CH | One PWM pin per channel |
| full_o | output | NUM_CH | Full-compare pulse per channel |

## Verification
A software load of the counter and the hardware wrap can fall in the same cycle. The bench polls a running channel until its counter reads the period value, then issues a counter write in that very cycle. It expects the full-compare pulse in that cycle, the written value in the next cycle with no 0 in between, and counting to resume from that value. A control write that clears the enable can also land while the counter sits mid-period. This case is judged for both shutdown modes against an expected pin trace computed by the bench.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // control field bit positions
  localparam int CTRL_EN   = 0;
  localparam int CTRL_INIT = 1;
  localparam int CTRL_SD   = 2;
  localparam int CTRL_W    = 3;

  typedef struct packed {
    logic sd;    // abrupt shutdown
    logic init;  // starting level
    logic en;    // pin enable
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_DUTY = 2'd2,
    REG_PER  = 2'd3
  } chan_reg_e;

  typedef enum logic [1:0] {
    G_STATUS = 2'd0,
    G_SET    = 2'd1,
    G_CLR    = 2'd2
  } glob_reg_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] wr_cnt,
  output logic [NUM_CH-1:0] wr_duty,
  output logic [NUM_CH-1:0] wr_per,
  output logic              wr_set,
  output logic              wr_clr
);

  localparam int CH_W = ADDR_W - 3;

  logic            shared_sel;
  logic            chan_sel;
  logic [CH_W-1:0] ch_idx;
  logic [1:0]      reg_sel;

  assign shared_sel = wr_en &  wr_addr[ADDR_W-1];
  assign chan_sel   = wr_en & ~wr_addr[ADDR_W-1];
  assign ch_idx     = wr_addr[ADDR_W-2:2];
  assign reg_sel    = wr_addr[1:0];

  assign wr_set = shared_sel && (reg_sel == G_SET);
  assign wr_clr = shared_sel && (reg_sel == G_CLR);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit        = chan_sel && (ch_idx == CH_W'(g));
    assign wr_ctrl[g] = hit && (reg_sel == REG_CTRL);
    assign wr_cnt[g]  = hit && (reg_sel == REG_CNT);
    assign wr_duty[g] = hit && (reg_sel == REG_DUTY);
    assign wr_per[g]  = hit && (reg_sel == REG_PER);
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_cnt_i,
  input  logic          wr_duty_i,
  input  logic          wr_per_i,
  input  logic [CW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] duty_o,
  output logic [CW-1:0] per_o,
  output logic          pwm_o,
  output logic          full_o
);

  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] duty_q, per_q;
  logic          gate_q, gate_d;
  logic          wrap;
  logic          active;
  logic          cnt_ce;

  // next state
  always_comb begin
    wrap   = run_i && (cnt_q == per_q);
    cnt_ce = wr_cnt_i | run_i;
    if (wr_cnt_i)  cnt_d = wdata_i;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;

    ctrl_d = wr_ctrl_i ? ctrl_t'(wdata_i[CTRL_W-1:0]) : ctrl_q;

    if (ctrl_d.en)      gate_d = 1'b1;
    else if (ctrl_d.sd) gate_d = 1'b0;
    else                gate_d = gate_q & ~wrap;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
      per_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      gate_q <= gate_d;
      if (cnt_ce)    cnt_q  <= cnt_d;
      if (wr_duty_i) duty_q <= wdata_i;
      if (wr_per_i)  per_q  <= wdata_i;
    end
  end

  assign active = (cnt_q >= duty_q) && (duty_q <= per_q);
  assign pwm_o  = gate_q ? (ctrl_q.init ^ active) : ctrl_q.init;
  assign full_o = wrap;
  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q == per_q && !wr_cnt_i) |=> (cnt_q == '0));

  // R2
  full_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && per_q != '0 && !wr_cnt_i && !wr_per_i) |=> !full_o);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_q));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> (cnt_q == $past(wdata_i)));

  // R8
  duty_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q > per_q) |-> (pwm_o == ctrl_q.init));

  // R9
  abrupt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && !wdata_i[CTRL_EN] && wdata_i[CTRL_SD])
      |=> (pwm_o == $past(wdata_i[CTRL_INIT])));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CW     = 16,
  parameter int ADDR_W = $clog2(NUM_CH) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] full_o
);

  localparam int CH_W = ADDR_W - 3;

  logic              rst_n_s;
  logic [NUM_CH-1:0] wr_ctrl, wr_cnt, wr_duty, wr_per;
  logic              wr_set, wr_clr;
  logic [NUM_CH-1:0] run_q, run_d;
  logic              run_ce;

  ctrl_t         ctrl_a [NUM_CH];
  logic [CW-1:0] cnt_a  [NUM_CH];
  logic [CW-1:0] duty_a [NUM_CH];
  logic [CW-1:0] per_a  [NUM_CH];

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pwm_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_ctrl (wr_ctrl),
    .wr_cnt  (wr_cnt),
    .wr_duty (wr_duty),
    .wr_per  (wr_per),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr)
  );

  // run bits: next state
  always_comb begin
    run_ce = wr_set | wr_clr;
    run_d  = run_q;
    if (wr_set) run_d = run_q |  wr_data[NUM_CH-1:0];
    if (wr_clr) run_d = run_q & ~wr_data[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    run_q <= '0;
    else if (run_ce) run_q <= run_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .run_i     (run_q[g]),
      .wr_ctrl_i (wr_ctrl[g]),
      .wr_cnt_i  (wr_cnt[g]),
      .wr_duty_i (wr_duty[g]),
      .wr_per_i  (wr_per[g]),
      .wdata_i   (wr_data),
      .ctrl_o    (ctrl_a[g]),
      .cnt_o     (cnt_a[g]),
      .duty_o    (duty_a[g]),
      .per_o     (per_a[g]),
      .pwm_o     (pwm_o[g]),
      .full_o    (full_o[g])
    );
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr[ADDR_W-1]) begin
      if (rd_addr[1:0] == G_STATUS) rd_data[NUM_CH-1:0] = run_q;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (rd_addr[ADDR_W-2:2] == CH_W'(i)) begin
          case (rd_addr[1:0])
            REG_CTRL: rd_data[CTRL_W-1:0] = ctrl_a[i];
            REG_CNT:  rd_data = cnt_a[i];
            REG_DUTY: rd_data = duty_a[i];
            default:  rd_data = per_a[i];
          endcase
        end
      end
    end
  end

  // R6
  run_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_set |=> ((run_q & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

  // R6
  run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_clr |=> ((run_q & $past(wr_data[NUM_CH-1:0])) == '0));

  // R2
  full_run_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((full_o & ~run_q) == '0));

endmodule

// File: tb/pwm_timer_bank_tb.sv
module pwm_timer_bank_tb;

  localparam int CLK_P  = 10;
  localparam int NUM_CH = 8;
  localparam int CW     = 16;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [CW-1:0]     wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [CW-1:0]     rd_data;
  logic [NUM_CH-1:0] pwm_o;
  logic [NUM_CH-1:0] full_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_timer_bank #(.NUM_CH(NUM_CH), .CW(CW), .ADDR_W(ADDR_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .pwm_o (pwm_o), .full_o (full_o)
  );

  function automatic logic [ADDR_W-1:0] ca(input int ch, input int r);
    return {1'b0, 3'(ch), 2'(r)};
  endfunction
  function automatic logic [ADDR_W-1:0] ga(input int r);
    return {1'b1, 3'd0, 2'(r)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic setup(input int ch, input int per, input int duty, input int ctrl);
    wr(ca(ch, 1), 0);
    wr(ca(ch, 2), duty);
    wr(ca(ch, 3), per);
    wr(ca(ch, 0), ctrl);
    wr(ga(1), 1 << ch);
  endtask

  // follow a running, enabled channel for n cycles against a model
  task automatic watch(input int ch, input int n, input string req);
    int c, d, p, ctl, ep, ef;
    rd(ca(ch, 2), d);
    rd(ca(ch, 3), p);
    rd(ca(ch, 0), ctl);
    rd(ca(ch, 1), c);
    for (int i = 0; i < n; i++) begin
      int ac;
      rd(ca(ch, 1), ac);
      check(ac == c, {req, " counter"}, ac, c);
      ep = ((ctl >> 1) & 1) ^ int'(c >= d && d <= p);
      check(pwm_o[ch] == ep[0], {req, " pwm"}, int'(pwm_o[ch]), ep);
      ef = int'(c == p);
      check(full_o[ch] == ef[0], {req, " full"}, int'(full_o[ch]), ef);
      @(negedge clk);
      c = (c == p) ? 0 : c + 1;
    end
  endtask

  task automatic wait_cnt(input int ch, input int val);
    int v;
    for (int i = 0; i < 40; i++) begin
      rd(ca(ch, 1), v);
      if (v == val) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    rd(ga(0), v);
    check(v == 0, "R1 status", v, 0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int r = 0; r < 4; r++) begin
        rd(ca(ch, r), v);
        check(v == 0, "R1 register", v, 0);
      end
    end
    check(pwm_o == '0, "R1 pwm", int'(pwm_o), 0);
    check(full_o == '0, "R1 full", int'(full_o), 0);
  endtask

  task automatic t_basic;        // R2 R3
    setup(0, 4, 2, 5);           // en + abrupt, low start
    watch(0, 12, "R2/R3 ch0");
  endtask

  task automatic t_init_high;    // R4
    setup(1, 5, 3, 3);           // en + init high
    watch(1, 12, "R4 ch1");
  endtask

  task automatic t_duty_over;    // R8
    setup(2, 4, 9, 1);
    for (int i = 0; i < 8; i++) begin
      check(pwm_o[2] == 1'b0, "R8 pwm", int'(pwm_o[2]), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_duty_now;     // R10
    wr(ca(1, 2), 4);
    watch(1, 8, "R10 ch1 duty");
    wr(ca(1, 3), 6);
    watch(1, 10, "R10 ch1 period");
    wr(ca(1, 3), 5);
  endtask

  task automatic t_collide;      // R7
    int v;
    wait_cnt(1, 5);
    check(full_o[1] == 1'b1, "R7 full at wrap", int'(full_o[1]), 1);
    wr_en = 1'b1; wr_addr = ca(1, 1); wr_data = 16'd2;
    @(negedge clk);
    wr_en = 1'b0;
    rd(ca(1, 1), v);
    check(v == 2, "R7 load wins", v, 2);
    @(negedge clk);
    rd(ca(1, 1), v);
    check(v == 3, "R7 resume", v, 3);
  endtask

  task automatic t_abrupt;       // R9 R5
    wait_cnt(0, 2);
    check(pwm_o[0] == 1'b1, "R9 active before", int'(pwm_o[0]), 1);
    wr_en = 1'b1; wr_addr = ca(0, 0); wr_data = 16'd4;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check(pwm_o[0] == 1'b0, "R9/R5 abrupt off", int'(pwm_o[0]), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_graceful;     // R9 R5
    int c, e;
    bit passed;
    setup(3, 6, 2, 1);
    wait_cnt(3, 3);
    wr_en = 1'b1; wr_addr = ca(3, 0); wr_data = 16'd0;
    @(negedge clk);
    wr_en = 1'b0;
    passed = 0;
    for (int i = 0; i < 12; i++) begin
      rd(ca(3, 1), c);
      e = int'(!passed && c >= 2);
      check(pwm_o[3] == e[0], "R9/R5 graceful", int'(pwm_o[3]), e);
      if (c == 6) passed = 1;
      @(negedge clk);
    end
  endtask

  task automatic t_setclr;       // R6
    int s0, s, c0, c;
    rd(ga(0), s0);
    check(s0 == 'hF, "R6 status", s0, 'hF);
    wr(ga(1), 0);
    rd(ga(0), s);
    check(s == s0, "R6 set zero", s, s0);
    wr(ga(2), 0);
    rd(ga(0), s);
    check(s == s0, "R6 clear zero", s, s0);
    wr(ga(2), 1 << 2);
    rd(ga(0), s);
    check(s == (s0 & ~4), "R6 clear ch2", s, s0 & ~4);
    rd(ca(2, 1), c0);
    repeat (3) @(negedge clk);
    rd(ca(2, 1), c);
    check(c == c0, "R6 stopped holds", c, c0);
    wr(ga(1), 1 << 2);
    rd(ga(0), s);
    check(s == s0, "R6 restart ch2", s, s0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_init_high;
    t_duty_over;
    t_duty_now;
    t_collide;
    t_abrupt;
    t_graceful;
    t_setclr;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run;
  end

endmodule